// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of a parallel NOR flash device. It watches host bus write cycles (address, data and an active-low write strobe) and decides which operation a multi-cycle write sequence asks for. Most commands are guarded by a two-write unlock key written at two fixed addresses. After the key comes a command byte that selects read/reset, identification (autoselect), program or erase. Erase needs a second unlock key and then a final byte that picks the whole chip or one sector.

The decoder reports its state on a mode output. When an operation is accepted, it raises a one-cycle start pulse together with the latched target address and data, for the program or erase engine to act on. That engine answers with a done input. While an erase of one sector is running, the host can pause it and later resume it. A pin selects whether the unlock addresses are compared in word or byte form. Any write that does not fit the expected step drops the decoder back to array read.

Top module: `nfc_cmd_decoder`

## Requirements
- R1: After reset the mode is array read (code 0), no start pulse is high and no write is pending.
- R2: Each high-to-low transition of `we_n` is taken as exactly one bus write, however long the strobe stays low. Address and data are captured on the clock where the low level is first seen.
- R3: Unlock addresses are compared on `addr[14:0]` in word mode (`byte_mode`=0): first key 5555h, second key 2AAAh, command cycle 5555h. In byte mode the 16-bit value {`addr[14:0]`,`addr_lsb`} is compared against AAAAh, 5555h and AAAAh. Address bits above bit 14 are not compared, and neither is `addr_lsb` in word mode.
- R4: A single write of data F0h at any address, made in array read or identification mode, returns the mode to array read. The keyed form (unlock, then F0h) does the same.
- R5: Unlock followed by 90h selects identification mode (code 1).
- R6: Unlock followed by A0h, then one more write of any address and data, gives a one-cycle `start_program` pulse. The full 16-bit data goes to `tgt_data` and the address to `tgt_addr`, and the mode becomes programming (code 2).
- R7: Unlock, 80h, unlock, then 10h at the command address gives a one-cycle `start_chip_erase` pulse and erasing mode (code 3).
- R8: Unlock, 80h, unlock, then 30h at any address gives a one-cycle `start_sector_erase` pulse and erasing mode (code 3). `tgt_sector` carries address bits 17 down to 12 of that write.
- R9: A write whose address or data does not fit the current step ends the sequence. The mode becomes array read and no start pulse is produced.
- R10: While programming or erasing, writes other than pause are ignored. On `op_done` the mode returns to array read.
- R11: During a sector erase, B0h at any address pauses it (mode code 4, `op_done` ignored). 30h at any address then resumes it (code 3).
- R12: B0h and 30h have no pause or resume effect outside a sector erase. During a chip erase they leave the mode in erasing.
- R13: Only data bits 7:0 are decoded as command bytes. Bits 15:8 never change a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Bus write strobe, active low |
| addr | input | 18 | Word address bits 17:0 of the bus cycle |
| addr_lsb | input | 1 | Byte select bit below bit 0, used in byte mode |
| data | input | 16 | Bus write data |
| byte_mode | input | 1 | 1 selects byte-form unlock addresses |
| op_done | input | 1 | Program/erase engine finished |
| mode | output | 3 | 0 array read, 1 identification, 2 programming, 3 erasing, 4 erase paused |
| start_program | output | 1 | One-cycle program start |
| start_chip_erase | output | 1 | One-cycle whole-chip erase start |
| start_sector_erase | output | 1 | One-cycle sector erase start |
| tgt_addr | output | 18 | Latched target address |
| tgt_data | output | 16 | Latched program data |
| tgt_sector | output | 6 | Sector field of the latched address |

## Verification
The assertions check on every cycle that a strobe follows only a low write enable and never lasts two cycles. They also check that the three start pulses are mutually exclusive and agree with the mode they enter, that no start happens while busy, that done ends programming, and that pause is entered only from erasing. Which command a sequence selects, and the exact address bits that key comparison honours in each addressing form, can only be shown by the bench. It sweeps a single flipped address bit over every position, every unlock step and both forms. It also shows that stray pause and resume writes, high data bytes and a long-held strobe are ignored.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_IDENT, ST_KEY1, ST_KEY2, ST_PGM_ARG,
    ST_ERK0, ST_ERK1, ST_ERK2,
    ST_PGM_BUSY, ST_CHIP_BUSY, ST_SECT_BUSY, ST_SECT_HOLD
  } seq_state_t;

  localparam logic [2:0] MD_ARRAY = 3'd0;
  localparam logic [2:0] MD_IDENT = 3'd1;
  localparam logic [2:0] MD_PGM   = 3'd2;
  localparam logic [2:0] MD_ERASE = 3'd3;
  localparam logic [2:0] MD_HOLD  = 3'd4;

  localparam logic [7:0] CB_KEY_A = 8'hAA;
  localparam logic [7:0] CB_KEY_B = 8'h55;
  localparam logic [7:0] CB_RESET = 8'hF0;
  localparam logic [7:0] CB_IDENT = 8'h90;
  localparam logic [7:0] CB_PGM   = 8'hA0;
  localparam logic [7:0] CB_ERASE = 8'h80;
  localparam logic [7:0] CB_CHIP  = 8'h10;
  localparam logic [7:0] CB_SECT  = 8'h30;
  localparam logic [7:0] CB_PAUSE = 8'hB0;

  localparam int KEY_W = 15;

  // Expected 16-bit comparison pattern for the first/second key address.
  function automatic logic [15:0] key_pattern(input logic bmode, input logic second);
    if (bmode) return second ? 16'h5555 : 16'hAAAA;
    else       return second ? 16'h2AAA : 16'h5555;
  endfunction

  // Word form compares addr[14:0]; byte form appends the byte select bit.
  function automatic logic key_hit(input logic [KEY_W-1:0] a, input logic lsb,
                                   input logic bmode, input logic second);
    logic [15:0] seen;
    seen = bmode ? {a, lsb} : {1'b0, a};
    return seen == key_pattern(bmode, second);
  endfunction

  function automatic logic [2:0] mode_of(input seq_state_t s);
    case (s)
      ST_IDENT:                  return MD_IDENT;
      ST_PGM_BUSY:               return MD_PGM;
      ST_CHIP_BUSY, ST_SECT_BUSY: return MD_ERASE;
      ST_SECT_HOLD:              return MD_HOLD;
      default:                   return MD_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nfc_we_sampler.sv
module nfc_we_sampler #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          addr_lsb,
  input  logic [DW-1:0] data,
  output logic          wr_stb,
  output logic [AW-1:0] cap_addr,
  output logic          cap_lsb,
  output logic [DW-1:0] cap_data
);

  logic we_q;
  logic we_fall;

  assign we_fall = we_q & ~we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      wr_stb   <= 1'b0;
      cap_addr <= '0;
      cap_lsb  <= 1'b0;
      cap_data <= '0;
    end else begin
      we_q   <= we_n;
      wr_stb <= we_fall;
      if (we_fall) begin
        cap_addr <= addr;
        cap_lsb  <= addr_lsb;
        cap_data <= data;
      end
    end
  end

  // R2: a strobe lasts one cycle and only follows a low write enable
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r2_strobe_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(we_n));

endmodule

// File: rtl/nfc_key_match.sv
module nfc_key_match #(
  parameter int AW = 18
) (
  input  logic [AW-1:0] cap_addr,
  input  logic          cap_lsb,
  input  logic          byte_mode,
  output logic          hit_first,
  output logic          hit_second
);
  import nfc_pkg::*;

  logic [KEY_W-1:0] key_bits;
  assign key_bits = cap_addr[KEY_W-1:0];

  // R3: bits above KEY_W-1 never reach the comparison
  assign hit_first  = key_hit(key_bits, cap_lsb, byte_mode, 1'b0);
  assign hit_second = key_hit(key_bits, cap_lsb, byte_mode, 1'b1);

  always_comb begin
    a_r3_keys_distinct: assert (!(hit_first && hit_second));
  end

endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [AW-1:0]       cap_addr,
  input  logic [DW-1:0]       cap_data,
  input  logic                hit_first,
  input  logic                hit_second,
  input  logic                op_done,
  output nfc_pkg::seq_state_t state,
  output logic                go_pgm,
  output logic                go_chip,
  output logic                go_sect,
  output logic [AW-1:0]       op_addr,
  output logic [DW-1:0]       op_data
);
  import nfc_pkg::*;

  seq_state_t nxt;
  logic       n_pgm, n_chip, n_sect;
  logic [7:0] cmd;

  // R13: only the low byte is a command
  assign cmd = cap_data[7:0];

  always_comb begin
    nxt    = state;
    n_pgm  = 1'b0;
    n_chip = 1'b0;
    n_sect = 1'b0;
    case (state)
      ST_PGM_BUSY, ST_CHIP_BUSY: begin
        if (op_done) nxt = ST_READ;
      end
      ST_SECT_BUSY: begin
        if (op_done) nxt = ST_READ;
        else if (wr_stb && cmd == CB_PAUSE) nxt = ST_SECT_HOLD;
      end
      ST_SECT_HOLD: begin
        if (wr_stb && cmd == CB_SECT) nxt = ST_SECT_BUSY;
      end
      default: begin
        if (wr_stb) begin
          nxt = ST_READ;
          case (state)
            ST_READ, ST_IDENT: begin
              if (cmd != CB_RESET && hit_first && cmd == CB_KEY_A) nxt = ST_KEY1;
            end
            ST_KEY1: if (hit_second && cmd == CB_KEY_B) nxt = ST_KEY2;
            ST_KEY2: begin
              if (hit_first) begin
                case (cmd)
                  CB_IDENT: nxt = ST_IDENT;
                  CB_PGM:   nxt = ST_PGM_ARG;
                  CB_ERASE: nxt = ST_ERK0;
                  default:  nxt = ST_READ;
                endcase
              end
            end
            ST_PGM_ARG: begin
              nxt   = ST_PGM_BUSY;
              n_pgm = 1'b1;
            end
            ST_ERK0: if (hit_first && cmd == CB_KEY_A) nxt = ST_ERK1;
            ST_ERK1: if (hit_second && cmd == CB_KEY_B) nxt = ST_ERK2;
            ST_ERK2: begin
              if (hit_first && cmd == CB_CHIP) begin
                nxt    = ST_CHIP_BUSY;
                n_chip = 1'b1;
              end else if (cmd == CB_SECT) begin
                nxt    = ST_SECT_BUSY;
                n_sect = 1'b1;
              end
            end
            default: nxt = ST_READ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_READ;
      go_pgm  <= 1'b0;
      go_chip <= 1'b0;
      go_sect <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      state   <= nxt;
      go_pgm  <= n_pgm;
      go_chip <= n_chip;
      go_sect <= n_sect;
      if (n_pgm || n_sect) op_addr <= cap_addr;
      if (n_pgm)           op_data <= cap_data;
    end
  end

  // R11: pause is entered only from a running sector erase
  a_r11_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECT_HOLD && $past(state) != ST_SECT_HOLD) |-> $past(state) == ST_SECT_BUSY);
  // R11: done does not end a paused erase
  a_r11_hold_ignores_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECT_HOLD && op_done && !wr_stb) |=> state == ST_SECT_HOLD);
  // R9: a step without a write never advances an unfinished sequence
  a_r9_idle_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && (state == ST_KEY1 || state == ST_KEY2 || state == ST_ERK0)) |=> $stable(state));

endmodule

// File: rtl/nfc_cmd_decoder.sv
module nfc_cmd_decoder #(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int SECT_LO = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_n,
  input  logic [AW-1:0]         addr,
  input  logic                  addr_lsb,
  input  logic [DW-1:0]         data,
  input  logic                  byte_mode,
  input  logic                  op_done,
  output logic [2:0]            mode,
  output logic                  start_program,
  output logic                  start_chip_erase,
  output logic                  start_sector_erase,
  output logic [AW-1:0]         tgt_addr,
  output logic [DW-1:0]         tgt_data,
  output logic [AW-SECT_LO-1:0] tgt_sector
);
  import nfc_pkg::*;

  logic          wr_stb;
  logic [AW-1:0] cap_addr;
  logic          cap_lsb;
  logic [DW-1:0] cap_data;
  logic          hit_first, hit_second;
  seq_state_t    state;

  nfc_we_sampler #(.AW(AW), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .addr_lsb(addr_lsb),
    .data(data), .wr_stb(wr_stb), .cap_addr(cap_addr), .cap_lsb(cap_lsb),
    .cap_data(cap_data)
  );

  nfc_key_match #(.AW(AW)) u_key (
    .cap_addr(cap_addr), .cap_lsb(cap_lsb), .byte_mode(byte_mode),
    .hit_first(hit_first), .hit_second(hit_second)
  );

  nfc_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cap_addr(cap_addr),
    .cap_data(cap_data), .hit_first(hit_first), .hit_second(hit_second),
    .op_done(op_done), .state(state), .go_pgm(start_program),
    .go_chip(start_chip_erase), .go_sect(start_sector_erase),
    .op_addr(tgt_addr), .op_data(tgt_data)
  );

  assign mode       = mode_of(state);
  assign tgt_sector = tgt_addr[AW-1:SECT_LO];

  // R6 R7 R8: start pulses never overlap
  a_r8_starts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_program, start_chip_erase, start_sector_erase}));
  a_r6_start_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
    start_program |-> mode == MD_PGM);
  a_r7_start_chip_mode: assert property (@(posedge clk) disable iff (!rst_n)
    start_chip_erase |-> mode == MD_ERASE);
  a_r8_start_sect_mode: assert property (@(posedge clk) disable iff (!rst_n)
    start_sector_erase |-> mode == MD_ERASE);
  // R10: nothing new starts while programming, and done releases it
  a_r10_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PGM) |=> !(start_program || start_chip_erase || start_sector_erase));
  a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PGM && op_done) |=> mode == MD_ARRAY);
  // R6: pulses last one cycle
  a_r6_prog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_program |=> !start_program);

endmodule

// File: tb/nfc_cmd_decoder_tb_top.sv
module nfc_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1;
  logic [17:0] addr = '0;
  logic        addr_lsb = 1'b0;
  logic [15:0] data = '0;
  logic        byte_mode = 1'b0;
  logic        op_done = 1'b0;
  logic [2:0]  mode;
  logic        start_program, start_chip_erase, start_sector_erase;
  logic [17:0] tgt_addr;
  logic [15:0] tgt_data;
  logic [5:0]  tgt_sector;

  int total = 0;
  int bad = 0;
  int n_pgm = 0, n_chip = 0, n_sect = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nfc_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .addr_lsb(addr_lsb),
    .data(data), .byte_mode(byte_mode), .op_done(op_done), .mode(mode),
    .start_program(start_program), .start_chip_erase(start_chip_erase),
    .start_sector_erase(start_sector_erase), .tgt_addr(tgt_addr),
    .tgt_data(tgt_data), .tgt_sector(tgt_sector)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_program)      n_pgm++;
      if (start_chip_erase)   n_chip++;
      if (start_sector_erase) n_sect++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // {addr, lsb} image of a key address, computed from the key values
  function automatic logic [18:0] kv(input logic bm, input logic second);
    logic [15:0] p;
    if (bm) begin
      p = second ? 16'h5555 : 16'hAAAA;
      return {3'b000, p};
    end
    p = second ? 16'h2AAA : 16'h5555;
    return {3'b000, p[14:0], 1'b0};
  endfunction

  task automatic wr(input logic [18:0] v, input logic [15:0] d, input int hold);
    @(negedge clk);
    addr = v[18:1]; addr_lsb = v[0]; data = d; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock_cmd(input logic [7:0] c);
    wr(kv(byte_mode, 1'b0), 16'h00AA, 2);
    wr(kv(byte_mode, 1'b1), 16'h0055, 2);
    wr(kv(byte_mode, 1'b0), {8'h00, c}, 2);
  endtask

  task automatic pulse_done;
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0, c0, s0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 pulses", {start_program, start_chip_erase, start_sector_erase}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", mode, 0);

    // R3 R9: single flipped address bit at each unlock step, both forms
    for (int bm = 0; bm < 2; bm++) begin
      for (int step = 0; step < 3; step++) begin
        for (int pos = 0; pos < 19; pos++) begin
          logic [18:0] v;
          logic [15:0] d;
          int          ex;
          byte_mode = bm[0];
          wr(19'h7_1234, 16'h00F0, 2);
          for (int s = 0; s < 3; s++) begin
            v = kv(byte_mode, s == 1);
            d = (s == 0) ? 16'h00AA : (s == 1) ? 16'h0055 : 16'h0090;
            if (s == step) v = v ^ (19'd1 << pos);
            wr(v, d, 2);
          end
          ex = (pos <= 15 && (bm == 1 || pos >= 1)) ? 0 : 1;
          chk($sformatf("R3 bm=%0d step=%0d pos=%0d", bm, step, pos), mode, ex);
        end
      end
    end

    // R5 then R4 single-write reset at an arbitrary address
    byte_mode = 1'b0;
    unlock_cmd(8'h90);
    chk("R5 ident", mode, 1);
    wr(19'h5_3C3C, 16'h12F0, 2);
    chk("R4 single reset", mode, 0);
    unlock_cmd(8'h90);
    unlock_cmd(8'hF0);
    chk("R4 keyed reset", mode, 0);

    // R13: high data byte ignored on every command cycle
    byte_mode = 1'b1;
    wr(kv(1'b1, 1'b0), 16'hFFAA, 2);
    wr(kv(1'b1, 1'b1), 16'h3C55, 2);
    wr(kv(1'b1, 1'b0), 16'hA590, 2);
    chk("R13 high byte", mode, 1);
    wr(19'h0, 16'h00F0, 2);

    // R2: a long-held strobe is one write
    byte_mode = 1'b0;
    wr(kv(1'b0, 1'b0), 16'h00AA, 20);
    wr(kv(1'b0, 1'b1), 16'h0055, 2);
    wr(kv(1'b0, 1'b0), 16'h0090, 2);
    chk("R2 long strobe", mode, 1);
    wr(19'h0, 16'h00F0, 2);

    // R6 program, R10 ignored writes then done
    p0 = n_pgm;
    unlock_cmd(8'hA0);
    wr({18'h3_1234, 1'b1}, 16'hBEEF, 2);
    chk("R6 prog pulse", n_pgm - p0, 1);
    chk("R6 prog addr", tgt_addr, 18'h3_1234);
    chk("R6 prog data", tgt_data, 16'hBEEF);
    chk("R6 prog mode", mode, 2);
    wr(19'h0, 16'h00F0, 2);
    unlock_cmd(8'hA0);
    chk("R10 busy ignores", mode, 2);
    chk("R10 no restart", n_pgm - p0, 1);
    pulse_done();
    chk("R10 done", mode, 0);

    // R6 in byte form
    byte_mode = 1'b1;
    unlock_cmd(8'hA0);
    wr({18'h0_0077, 1'b0}, 16'h00C3, 2);
    chk("R6 byte prog pulse", n_pgm - p0, 2);
    chk("R6 byte prog data", tgt_data, 16'h00C3);
    pulse_done();
    byte_mode = 1'b0;

    // R7 chip erase, R12 pause ignored
    c0 = n_chip;
    unlock_cmd(8'h80);
    unlock_cmd(8'h10);
    chk("R7 chip pulse", n_chip - c0, 1);
    chk("R7 chip mode", mode, 3);
    wr(19'h0, 16'h00B0, 2);
    chk("R12 pause in chip erase", mode, 3);
    pulse_done();
    chk("R10 chip done", mode, 0);

    // R8 sector erase, R11 pause/resume
    s0 = n_sect;
    unlock_cmd(8'h80);
    wr(kv(1'b0, 1'b0), 16'h00AA, 2);
    wr(kv(1'b0, 1'b1), 16'h0055, 2);
    wr({18'h2_A123, 1'b0}, 16'h0030, 2);
    chk("R8 sect pulse", n_sect - s0, 1);
    chk("R8 sector field", tgt_sector, 6'h2A);
    chk("R8 sect mode", mode, 3);
    wr(19'h1_0000, 16'h00B0, 2);
    chk("R11 paused", mode, 4);
    pulse_done();
    chk("R11 done ignored", mode, 4);
    wr(19'h0_0F00, 16'h0030, 2);
    chk("R11 resumed", mode, 3);
    chk("R11 no new start", n_sect - s0, 1);
    pulse_done();
    chk("R11 done", mode, 0);

    // R12: pause/resume bytes outside an erase
    wr(19'h0, 16'h00B0, 2);
    chk("R12 pause in read", mode, 0);
    wr(19'h0, 16'h0030, 2);
    chk("R12 resume in read", mode, 0);
    chk("R12 no sector start", n_sect - s0, 1);

    // R9: wrong cycles inside the erase sequence
    unlock_cmd(8'h80);
    wr(kv(1'b0, 1'b0), 16'h00AA, 2);
    wr(kv(1'b0, 1'b1), 16'h0055, 2);
    wr(kv(1'b0, 1'b1), 16'h0010, 2);
    chk("R9 chip at wrong addr", mode, 0);
    chk("R9 no chip start", n_chip - c0, 1);
    unlock_cmd(8'h80);
    wr(kv(1'b0, 1'b0), 16'h0055, 2);
    wr(kv(1'b0, 1'b1), 16'h0055, 2);
    wr(kv(1'b0, 1'b0), 16'h0010, 2);
    chk("R9 bad second key", mode, 0);
    chk("R9 no chip start 2", n_chip - c0, 1);
    unlock_cmd(8'h77);
    chk("R9 unknown cmd", mode, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule